// File: doc/BRIEF.md
# Transmit Prefetch Buffer Controller

This block keeps a small transmit byte buffer topped up for one serial time-slot engine. The bytes to send sit in a circular region of memory. Each 64-bit word there carries the same slot position for eight consecutive frames, one byte lane per frame. The controller walks that region one slot at a time. It sends word reads over a simple request/ready port and takes the in-order responses. From each word it keeps only the byte lane that belongs to the frame being read, and queues that byte for the shifter. The shifter takes bytes through a pop interface.

Refills are driven by a threshold. A burst starts when the buffered byte count falls to the programmed threshold or below. The burst reads the programmed fetch size plus one slots, but never more than one frame's worth of slots.

The read pointer has three parts: a word address, a slot index and a 3-bit byte-lane offset. After the last slot of a frame the offset advances. After lane 7 the base moves on by one frame's worth of slots, which is one superframe. After the last superframe the pointer returns to the region start.

The block raises these signals:
- a pulse every programmed number of frames read;
- a pulse on each region wrap;
- a pending flag while responses are owed;
- a configuration-error flag when the settings could overrun the buffer.

An engine can only be enabled again once no reads are pending.

Top module: `tpf_tx_prefetch`

## Requirements
- R1: The engine becomes active one cycle after `en_i` is sampled high, provided no reads are pending and the configuration is valid. On activation the pointer loads the start address with slot 0 and lane 0. While `en_i` is low the engine is inactive, buffered bytes are discarded, and responses that arrive while inactive are not buffered.
- R2: `pending_o` is high exactly while at least one accepted read has not yet received its response. Activation is held off for as long as `pending_o` is high.
- R3: `cfg_err_o` is high when the threshold plus min(fetch+1, slots per frame) exceeds the 16-byte buffer capacity, when slots per frame is 0, or when the region length is 0. The engine never activates while `cfg_err_o` is high.
- R4: While active with no burst in progress, a buffered count at or below the threshold starts a burst, and requests appear on the next cycle. A count above the threshold starts nothing.
- R5: A burst issues exactly min(fetch+1, slots per frame) accepted reads. The next burst is considered only after every response of the current burst has returned.
- R6: Each request address is the frame base plus the slot index, and `next_off_o` is the lane in use. After the last slot of a frame the slot index returns to 0 and the lane increments, with the base unchanged. After lane 7 the lane becomes 0 and the base advances by the slots-per-frame value.
- R7: For each response, the byte kept is data bits [8*lane+7 : 8*lane], where lane is the one recorded when that request was accepted. Bytes are queued in response order.
- R8: The read after the last slot of lane 7 of the final superframe causes a wrap. The pointer returns to the start address with lane 0, and `wrap_ev_o` pulses for one cycle, in the cycle after that read is accepted.
- R9: `frame_ev_o` pulses in the cycle after the accepted read that completes each group of `cfg_frm_int_i` frames. Groups are counted from activation or from the previous pulse. A value of 0 disables the pulse.
- R10: `pop_data_o` shows the oldest buffered byte, and a pop removes that byte. A pop while the buffer is empty shows 0 and removes nothing, and `tx_under_o` pulses in the following cycle.
- R11: With a valid configuration, the buffered count never exceeds 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Engine enable request |
| cfg_start_i | input | 33 | Region start word address |
| cfg_sframes_i | input | 16 | Region length in superframes |
| cfg_slots_i | input | 10 | Slots per frame |
| cfg_thresh_i | input | 4 | Refill threshold in bytes |
| cfg_fetch_i | input | 4 | Burst size minus one, in slots |
| cfg_frm_int_i | input | 10 | Frames per frame-read event (0 = off) |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 33 | Read word address |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read response valid (in order) |
| mem_rdata_i | input | 64 | Read response word |
| pop_i | input | 1 | Shifter takes one byte |
| pop_data_o | output | 8 | Oldest buffered byte, 0 when empty |
| tx_under_o | output | 1 | Pop-on-empty pulse |
| next_addr_o | output | 33 | Word address of the next read |
| next_off_o | output | 3 | Byte lane of the next read |
| pending_o | output | 1 | Responses outstanding |
| active_o | output | 1 | Engine running |
| frame_ev_o | output | 1 | Frame-read event pulse |
| wrap_ev_o | output | 1 | Region-wrap event pulse |
| cfg_err_o | output | 1 | Configuration would overrun the buffer |

## Verification
Each result has a fixed latency:

| Result | When it is due |
|---|---|
| `pop_data_o`, `cfg_err_o` | Same cycle (combinational from state and inputs) |
| `active_o` | One edge after `en_i` is sampled |
| First request | One edge after activation |
| `frame_ev_o`, `wrap_ev_o`, updated pointer | One edge after the accepting edge of the read |
| `tx_under_o` | One edge after an empty pop |
| A returned byte in the buffer | On the edge that carries its response |

The bench drives every input on the falling edge, so each input takes effect at the next rising edge. It evaluates outputs on the falling edge, after they have settled from the previous rising edge. Its walker model, its queue of outstanding reads and its byte queue advance in the same order as those edges. As a result each expected pulse, flag and byte is compared in exactly the cycle it is due.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ISSUE,
    FS_DRAIN
  } fetch_st_e;

  // Slots fetched per refill: the requested burst capped at one frame.
  function automatic int burst_len(input int fetch, input int slots);
    int want;
    want = fetch + 1;
    return (want < slots) ? want : slots;
  endfunction

  // Settings that could overrun the buffer or walk an empty region.
  function automatic logic cfg_bad(input int thresh, input int fetch,
                                   input int slots, input int sframes,
                                   input int cap);
    return (slots == 0) || (sframes == 0) ||
           ((thresh + burst_len(fetch, slots)) > cap);
  endfunction

endpackage

// File: rtl/tpf_fifo.sv
module tpf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;
  logic          empty_w, do_pop, do_push;

  assign empty_w = (cnt_q == '0);
  assign do_pop  = pop && !empty_w;
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign rdata = empty_w ? '0 : mem[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/tpf_walker.sv
module tpf_walker #(
  parameter int AW     = 33,
  parameter int SLOT_W = 10,
  parameter int SF_W   = 16,
  parameter int FRM_W  = 10,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [AW-1:0]     start_addr,
  input  logic [SLOT_W-1:0] slots,
  input  logic [SF_W-1:0]   sframes,
  input  logic [FRM_W-1:0]  frm_int,
  output logic [AW-1:0]     word_addr,
  output logic [OFF_W-1:0]  offset,
  output logic              frame_ev,
  output logic              wrap_ev
);

  logic [AW-1:0]     base_q;
  logic [SLOT_W-1:0] slot_q;
  logic [OFF_W-1:0]  off_q;
  logic [SF_W-1:0]   sf_q;
  logic [FRM_W-1:0]  frm_q;
  logic              last_slot, last_off, last_sf, frm_hit;

  assign last_slot = (slot_q == slots - SLOT_W'(1));
  assign last_off  = (off_q == '1);
  assign last_sf   = (sf_q == sframes - SF_W'(1));
  assign frm_hit   = (frm_int != '0) && ((frm_q + FRM_W'(1)) == frm_int);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      slot_q   <= '0;
      off_q    <= '0;
      sf_q     <= '0;
      frm_q    <= '0;
      frame_ev <= 1'b0;
      wrap_ev  <= 1'b0;
    end else begin
      frame_ev <= 1'b0;
      wrap_ev  <= 1'b0;
      if (load) begin
        base_q <= start_addr;
        slot_q <= '0;
        off_q  <= '0;
        sf_q   <= '0;
        frm_q  <= '0;
      end else if (step) begin
        if (last_slot) begin
          slot_q   <= '0;
          frame_ev <= frm_hit;
          frm_q    <= frm_hit ? '0 : frm_q + FRM_W'(1);
          if (last_off) begin
            off_q <= '0;
            if (last_sf) begin
              base_q  <= start_addr;
              sf_q    <= '0;
              wrap_ev <= 1'b1;
            end else begin
              base_q <= base_q + AW'(slots);
              sf_q   <= sf_q + SF_W'(1);
            end
          end else begin
            off_q <= off_q + OFF_W'(1);
          end
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end

  assign word_addr = base_q + AW'(slot_q);
  assign offset    = off_q;

endmodule

// File: rtl/tpf_tx_prefetch.sv
module tpf_tx_prefetch
  import tpf_pkg::*;
#(
  parameter int AW        = 33,
  parameter int DATA_W    = 64,
  parameter int BUF_DEPTH = 16,
  parameter int SLOT_W    = 10,
  parameter int SF_W      = 16,
  parameter int FRM_W     = 10,
  parameter int CFG_W     = 4,
  localparam int OFF_W    = $clog2(DATA_W / 8),
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [AW-1:0]     cfg_start_i,
  input  logic [SF_W-1:0]   cfg_sframes_i,
  input  logic [SLOT_W-1:0] cfg_slots_i,
  input  logic [CFG_W-1:0]  cfg_thresh_i,
  input  logic [CFG_W-1:0]  cfg_fetch_i,
  input  logic [FRM_W-1:0]  cfg_frm_int_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              pop_i,
  output logic [7:0]        pop_data_o,
  output logic              tx_under_o,
  output logic [AW-1:0]     next_addr_o,
  output logic [OFF_W-1:0]  next_off_o,
  output logic              pending_o,
  output logic              active_o,
  output logic              frame_ev_o,
  output logic              wrap_ev_o,
  output logic              cfg_err_o
);

  fetch_st_e         st_q;
  logic              act_q, under_q;
  logic [CNT_W-1:0]  outst_q, issued_q, blen_w;
  logic [CNT_W-1:0]  buf_cnt, tag_cnt;
  logic [OFF_W-1:0]  tag_rd;
  logic [7:0]        lane_w;
  logic              activate_w, issue_w, resp_w, refill_w, buf_push;

  // Named internal events (also observed by the checker)
  assign cfg_err_o  = cfg_bad(int'(cfg_thresh_i), int'(cfg_fetch_i),
                              int'(cfg_slots_i), int'(cfg_sframes_i), BUF_DEPTH);
  assign blen_w     = CNT_W'(burst_len(int'(cfg_fetch_i), int'(cfg_slots_i)));
  assign pending_o  = (outst_q != '0);
  assign activate_w = en_i && !act_q && !pending_o && !cfg_err_o;
  assign mem_req_o  = act_q && (st_q == FS_ISSUE);
  assign issue_w    = mem_req_o && mem_ready_i;
  assign resp_w     = mem_rvalid_i && (tag_cnt != '0);
  assign refill_w   = act_q && (st_q == FS_IDLE) && (buf_cnt <= CNT_W'(cfg_thresh_i));
  assign buf_push   = resp_w && act_q;
  assign lane_w     = mem_rdata_i[8*int'(tag_rd) +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      st_q     <= FS_IDLE;
      issued_q <= '0;
      outst_q  <= '0;
      under_q  <= 1'b0;
    end else begin
      if (!en_i)           act_q <= 1'b0;
      else if (activate_w) act_q <= 1'b1;

      outst_q <= outst_q + CNT_W'(issue_w) - CNT_W'(resp_w);
      under_q <= pop_i && (buf_cnt == '0);

      case (st_q)
        FS_IDLE: begin
          if (refill_w) begin
            st_q     <= FS_ISSUE;
            issued_q <= '0;
          end
        end
        FS_ISSUE: begin
          if (!act_q) begin
            st_q <= FS_DRAIN;
          end else if (issue_w) begin
            issued_q <= issued_q + CNT_W'(1);
            if ((issued_q + CNT_W'(1)) == blen_w) st_q <= FS_DRAIN;
          end
        end
        default: begin
          if (outst_q == '0) st_q <= FS_IDLE;
        end
      endcase
    end
  end

  tpf_walker #(
    .AW(AW), .SLOT_W(SLOT_W), .SF_W(SF_W), .FRM_W(FRM_W), .OFF_W(OFF_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (activate_w),
    .step       (issue_w),
    .start_addr (cfg_start_i),
    .slots      (cfg_slots_i),
    .sframes    (cfg_sframes_i),
    .frm_int    (cfg_frm_int_i),
    .word_addr  (next_addr_o),
    .offset     (next_off_o),
    .frame_ev   (frame_ev_o),
    .wrap_ev    (wrap_ev_o)
  );

  // Lane of every read in flight, consumed in response order
  tpf_fifo #(.W(OFF_W), .DEPTH(BUF_DEPTH)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (1'b0),
    .push  (issue_w),
    .wdata (next_off_o),
    .pop   (resp_w),
    .rdata (tag_rd),
    .count (tag_cnt)
  );

  tpf_fifo #(.W(8), .DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!act_q),
    .push  (buf_push),
    .wdata (lane_w),
    .pop   (pop_i),
    .rdata (pop_data_o),
    .count (buf_cnt)
  );

  assign mem_addr_o = next_addr_o;
  assign active_o   = act_q;
  assign tx_under_o = under_q;

endmodule

// File: rtl/tpf_tx_prefetch_chk.sv
module tpf_tx_prefetch_chk #(
  parameter int CNT_W = 5,
  parameter int CW    = 4,
  parameter int AW    = 33,
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             fetch_idle,
  input logic             pending,
  input logic             cfg_err,
  input logic             mem_req,
  input logic             tx_under,
  input logic             pop,
  input logic             wrap,
  input logic [CNT_W-1:0] buf_cnt,
  input logic [CW-1:0]    thresh,
  input logic [AW-1:0]    next_addr,
  input logic [AW-1:0]    start,
  input logic [OFF_W-1:0] next_off
);

  // R4
  refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fetch_idle && (buf_cnt <= CNT_W'(thresh))) |=> (mem_req || !active));

  // R2
  no_enable_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !$past(pending));

  // R3
  no_enable_on_bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !$past(cfg_err));

  // R10
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_under |-> $past(pop));

  // R8
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ((next_off == '0) && (next_addr == start)));

endmodule

bind tpf_tx_prefetch tpf_tx_prefetch_chk #(
  .CNT_W(CNT_W), .CW(CFG_W), .AW(AW), .OFF_W(OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active_o),
  .fetch_idle (st_q == tpf_pkg::FS_IDLE),
  .pending    (pending_o),
  .cfg_err    (cfg_err_o),
  .mem_req    (mem_req_o),
  .tx_under   (tx_under_o),
  .pop        (pop_i),
  .wrap       (wrap_ev_o),
  .buf_cnt    (buf_cnt),
  .thresh     (cfg_thresh_i),
  .next_addr  (next_addr_o),
  .start      (cfg_start_i),
  .next_off   (next_off_o)
);

// File: tb/tpf_tx_prefetch_tb.sv
module tpf_tx_prefetch_tb;
  localparam int AW = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          en_i = 1'b0;
  logic [AW-1:0] cfg_start = '0;
  logic [15:0]   cfg_sframes = 16'd2;
  logic [9:0]    cfg_slots = 10'd5;
  logic [3:0]    cfg_thresh = 4'd2;
  logic [3:0]    cfg_fetch = 4'd3;
  logic [9:0]    cfg_frm_int = 10'd3;
  logic          mem_ready = 1'b0, mem_rvalid = 1'b0, pop = 1'b0;
  logic [63:0]   mem_rdata = '0;
  logic          mem_req_o, tx_under_o, pending_o, active_o;
  logic          frame_ev_o, wrap_ev_o, cfg_err_o;
  logic [AW-1:0] mem_addr_o, next_addr_o;
  logic [7:0]    pop_data_o;
  logic [2:0]    next_off_o;

  tpf_tx_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .cfg_start_i(cfg_start), .cfg_sframes_i(cfg_sframes), .cfg_slots_i(cfg_slots),
    .cfg_thresh_i(cfg_thresh), .cfg_fetch_i(cfg_fetch), .cfg_frm_int_i(cfg_frm_int),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pop_i(pop), .pop_data_o(pop_data_o), .tx_under_o(tx_under_o),
    .next_addr_o(next_addr_o), .next_off_o(next_off_o), .pending_o(pending_o),
    .active_o(active_o), .frame_ev_o(frame_ev_o), .wrap_ev_o(wrap_ev_o),
    .cfg_err_o(cfg_err_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench model state
  longint     m_base;
  int         m_slot, m_off, m_sf, m_frm;
  bit         m_act = 0, en_next = 0, hold = 0, pop_on = 0;
  int         pop_pct = 0, rdy_pct = 100, rsp_pct = 100;
  logic [AW-1:0] aq_a [64];
  int         aq_o [64];
  int         aq_h = 0, aq_n = 0;
  logic [7:0] bq [64];
  int         bq_h = 0, bq_n = 0;
  bit         exp_fe = 0, exp_we = 0, exp_un = 0;
  int         hs_total = 0, fe_seen = 0, we_seen = 0;

  function automatic logic [63:0] word_of(input longint a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = 8'((a * 29 + k * 53 + 7) & 255);
    return w;
  endfunction

  function automatic bit bad_cfg();
    int want, b;
    want = int'(cfg_fetch) + 1;
    b = (want < int'(cfg_slots)) ? want : int'(cfg_slots);
    return (cfg_slots == 0) || (cfg_sframes == 0) || (int'(cfg_thresh) + b > 16);
  endfunction

  task automatic model_step(output bit fe, output bit we);
    fe = 0; we = 0;
    if (m_slot == int'(cfg_slots) - 1) begin
      m_slot = 0;
      m_frm++;
      if (cfg_frm_int != 0 && m_frm == int'(cfg_frm_int)) begin fe = 1; m_frm = 0; end
      if (m_off == 7) begin
        m_off = 0;
        m_sf++;
        if (m_sf == int'(cfg_sframes)) begin m_sf = 0; m_base = longint'(cfg_start); we = 1; end
        else m_base += longint'(cfg_slots);
      end else m_off++;
    end else m_slot++;
  endtask

  task automatic tick();
    bit new_act, fe, we;
    logic [63:0] w;
    @(negedge clk);
    mem_rvalid = 1'b0;
    pop = 1'b0;
    en_i = en_next;
    chk("R9 frame event", frame_ev_o, exp_fe);
    chk("R8 wrap event", wrap_ev_o, exp_we);
    chk("R10 underflow pulse", tx_under_o, exp_un);
    fe_seen += int'(frame_ev_o);
    we_seen += int'(wrap_ev_o);
    chk("R1 active", active_o, m_act);
    chk("R2 pending", pending_o, aq_n != 0);
    if (!m_act) bq_n = 0;
    exp_fe = 0; exp_we = 0; exp_un = 0;
    new_act = en_i && (m_act || (aq_n == 0 && !bad_cfg()));
    if (pop_on && m_act && ($urandom % 100) < pop_pct) begin
      pop = 1'b1;
      if (bq_n > 0) begin
        chk("R10 pop data", pop_data_o, bq[bq_h]);
        bq_h = (bq_h + 1) % 64; bq_n--;
      end else begin
        chk("R10 empty data", pop_data_o, 0);
        exp_un = 1;
      end
    end
    if (!hold && aq_n > 0 && ($urandom % 100) < rsp_pct) begin
      mem_rvalid = 1'b1;
      mem_rdata = word_of(longint'(aq_a[aq_h]));
      if (m_act) begin
        w = mem_rdata;
        bq[(bq_h + bq_n) % 64] = w[8*aq_o[aq_h] +: 8];  // R7 lane of issue time
        bq_n++;
      end
      aq_h = (aq_h + 1) % 64; aq_n--;
    end
    mem_ready = (($urandom % 100) < rdy_pct);
    if (mem_req_o) begin
      if (!m_act) chk("R1 request while inactive", mem_req_o, 0);
      if (mem_ready) begin
        chk("R6 address", longint'(mem_addr_o), m_base + m_slot);
        chk("R6 offset", next_off_o, m_off);
        aq_a[(aq_h + aq_n) % 64] = mem_addr_o;
        aq_o[(aq_h + aq_n) % 64] = m_off;
        aq_n++;
        hs_total++;
        model_step(fe, we);
        exp_fe = fe; exp_we = we;
      end
    end
    if (bq_n > 16) chk("R11 capacity", bq_n, 16);
    if (new_act && !m_act) begin
      m_base = longint'(cfg_start); m_slot = 0; m_off = 0; m_sf = 0; m_frm = 0;
    end
    m_act = new_act;
  endtask

  task automatic pops(input int n);
    pop_on = 1; pop_pct = 100;
    repeat (n) tick();
    pop_on = 0;
  endtask

  task automatic quiesce();
    en_next = 0; hold = 0; rsp_pct = 100; rdy_pct = 100; pop_on = 0;
    repeat (12) tick();
  endtask

  initial begin
    int base_hs;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset active", active_o, 0);
    chk("R2 reset pending", pending_o, 0);
    chk("R1 reset request", mem_req_o, 0);
    chk("R10 reset pop data", pop_data_o, 0);
    chk("R9 reset frame event", frame_ev_o, 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R3 capacity rule boundaries
    cfg_slots = 10'd3; cfg_fetch = 4'd15; cfg_thresh = 4'd13; tick();
    chk("R3 sum 16 accepted", cfg_err_o, 0);
    cfg_thresh = 4'd14; tick();
    chk("R3 sum 17 rejected", cfg_err_o, 1);
    cfg_slots = 10'd10; cfg_fetch = 4'd7; cfg_thresh = 4'd12; tick();
    chk("R3 sum 20 rejected", cfg_err_o, 1);
    en_next = 1; repeat (10) tick();
    chk("R3 no activation on error", active_o, 0);
    en_next = 0; cfg_thresh = 4'd2; cfg_slots = 10'd0; tick();
    chk("R3 zero slots rejected", cfg_err_o, 1);

    // Directed threshold / burst test
    cfg_start = 33'd100; cfg_slots = 10'd5; cfg_sframes = 16'd2;
    cfg_thresh = 4'd2; cfg_fetch = 4'd3; cfg_frm_int = 10'd3;
    repeat (2) tick();
    chk("R3 valid config", cfg_err_o, 0);
    en_next = 1; repeat (30) tick();
    chk("R5 burst length", hs_total, 4);
    pops(1); repeat (20) tick();
    chk("R4 above threshold idle", hs_total, 4);
    pops(1); repeat (20) tick();
    chk("R4 at threshold refills", hs_total, 8);
    hold = 1; pops(9); hold = 0; repeat (20) tick();
    pops(20);

    // Pending blocks re-enable
    quiesce();
    hold = 1; en_next = 1; repeat (12) tick();
    chk("R2 pending while held", pending_o, 1);
    en_next = 0; repeat (3) tick();
    chk("R1 disabled", active_o, 0);
    en_next = 1; repeat (6) tick();
    chk("R2 re-enable refused", active_o, 0);
    hold = 0; repeat (12) tick();
    chk("R1 re-enabled after drain", active_o, 1);
    repeat (10) tick();
    pops(4);

    // Random run 1: wraps and frame events
    quiesce();
    cfg_start = 33'h1_0000_0F00; cfg_slots = 10'd3; cfg_sframes = 16'd2;
    cfg_thresh = 4'd4; cfg_fetch = 4'd5; cfg_frm_int = 10'd5;
    repeat (2) tick();
    base_hs = we_seen;
    en_next = 1; pop_on = 1; pop_pct = 55; rdy_pct = 70; rsp_pct = 60;
    repeat (3000) tick();
    chk("R8 wraps observed", we_seen > base_hs, 1);
    chk("R9 frame events observed", fe_seen > 0, 1);

    // Random run 2: single superframe, threshold 0, frame events off
    quiesce();
    cfg_start = 33'd4000; cfg_slots = 10'd7; cfg_sframes = 16'd1;
    cfg_thresh = 4'd0; cfg_fetch = 4'd15; cfg_frm_int = 10'd0;
    repeat (2) tick();
    base_hs = fe_seen;
    en_next = 1; pop_on = 1; pop_pct = 40; rdy_pct = 80; rsp_pct = 70;
    repeat (3000) tick();
    chk("R9 disabled count", fe_seen, base_hs);
    quiesce();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule